// File: doc/BRIEF.md
# Octal SPI Data Lane Router

This block sits between a serial memory controller's shift datapath and an 8-pin bidirectional pad bus. On each bit-cycle the datapath hands it a byte of transmit bits plus a drive flag. The router places those bits on the pins that belong to the current lane arrangement, and it gathers the received bits from the pins back into a byte. Four arrangements are supported:

- a single 1/2/4-line device on pins 0..3;
- a single device on pins 4..7;
- two 4-pin devices worked side by side, each taking its own slice of the byte;
- a full 8-line device.

The lane configuration is held in a small register. It loads from a write strobe only while the controller reports that no transfer is in progress, so the routing cannot move in the middle of a transfer. The transmit/receive paths through the router are combinational from that register, so the router adds no cycles of latency to the serial data.

Top module: `octal_lane_router`

## Requirements
- R1: With `cfg_octal`=0, `cfg_dual`=0 and `cfg_fsel`=0, transmit bits `tx_data[w-1:0]` drive pins `w-1..0`. Only those pins have `pad_oe` set, and `rx_data[w-1:0]` is taken from pins `w-1..0`. Here w is the active line count.
- R2: With `cfg_octal`=0, `cfg_dual`=0 and `cfg_fsel`=1, the same mapping is applied to pins `4+w-1..4`. Pins 0..3 are never enabled.
- R3: With `cfg_dual`=1 and `cfg_octal`=0:
  - `tx_data[w-1:0]` goes to pins `w-1..0` and `tx_data[2w-1:w]` goes to pins `4+w-1..4`.
  - `rx_data` is assembled the same way from the two pin groups.
  - `cfg_fsel` has no effect.
- R4: With `cfg_octal`=1, `tx_data` maps straight onto pins 7..0 and `rx_data` equals `pad_in`. Octal takes priority over `cfg_dual`, and `cfg_fsel` and `cfg_lines` have no effect.
- R5: `cfg_lines` encodes the line count w as 00=1, 01=2, 10=4 and 11=4. With w=1 the device's transmit bit uses the lowest pin of its nibble (pin 0 or 4), and its receive bit is sampled from the next pin up (pin 1 or 5).
- R6: A configuration write (`cfg_we`=1) is captured at a rising clock edge only when `busy`=0, and takes effect from that edge. A write while `busy`=1 leaves the configuration unchanged.
- R7: Pins that the current arrangement does not use have `pad_oe`=0 and `pad_out`=0. `rx_data` bits beyond the active width read 0.
- R8: While `tx_oe`=0, every `pad_oe` and `pad_out` bit is 0, and `rx_data` is still routed.
- R9: Synchronous active-high reset selects the arrangement of R1 with w=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy | input | 1 | Transfer in progress; blocks configuration writes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_fsel | input | 1 | Narrow-mode device select: 0 = pins 0..3, 1 = pins 4..7 |
| cfg_dual | input | 1 | Two-device side-by-side enable |
| cfg_octal | input | 1 | Full 8-line enable |
| cfg_lines | input | 2 | Line count per device (00=1, 01=2, 1x=4) |
| tx_data | input | 8 | Transmit bits for this bit-cycle |
| tx_oe | input | 1 | Drive the pins this bit-cycle |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output levels |
| pad_oe | output | 8 | Pad output enables |
| rx_data | output | 8 | Received bits gathered from the pads |

## Verification
The same transmit byte (`A5`) and pad input (`96`) are pushed through every combination of arrangement and line count. Because each pin of both values carries a distinct level, any swapped nibble, misplaced slice or wrong single-line receive pin shows up as a different output byte.

Octal is tried with `cfg_dual` and `cfg_fsel` set, which separates the priority of octal from a fall-through into the two-device or upper-nibble paths. Line code 11 and a busy-time write probe the encoding alias and the freeze. A receive-only cycle in octal confirms that the enables drop while input routing continues.

// File: rtl/olr_pkg.sv
package olr_pkg;

    localparam int NIB_W = 4;
    localparam int IO_W  = 2 * NIB_W;
    localparam int SRC_W = $clog2(IO_W);

    typedef enum logic [1:0] {
        ROUTE_LO  = 2'd0,
        ROUTE_HI  = 2'd1,
        ROUTE_DQ  = 2'd2,
        ROUTE_OCT = 2'd3
    } route_e;

    typedef struct packed {
        logic       fsel;
        logic       dual;
        logic       octal;
        logic [1:0] lines;
    } cfg_t;

    typedef struct packed {
        logic             en;
        logic [SRC_W-1:0] src;
    } lane_t;

    localparam cfg_t CFG_RESET = '{fsel: 1'b0, dual: 1'b0, octal: 1'b0, lines: 2'b00};

    function automatic route_e decode_route(cfg_t c);
        if (c.octal)     return ROUTE_OCT;
        else if (c.dual) return ROUTE_DQ;
        else if (c.fsel) return ROUTE_HI;
        else             return ROUTE_LO;
    endfunction

    function automatic int unsigned lane_count(logic [1:0] l);
        case (l)
            2'b00:   return 1;
            2'b01:   return 2;
            default: return NIB_W;
        endcase
    endfunction

    // Source bit of tx_data for pad pin p
    function automatic lane_t tx_route(route_e m, int unsigned w, int unsigned p);
        lane_t r;
        int unsigned nib = p / NIB_W;
        int unsigned k   = p % NIB_W;
        r = '0;
        case (m)
            ROUTE_OCT: begin
                r.en  = 1'b1;
                r.src = SRC_W'(p);
            end
            ROUTE_LO: begin
                r.en  = (nib == 0) && (k < w);
                r.src = SRC_W'(k);
            end
            ROUTE_HI: begin
                r.en  = (nib == 1) && (k < w);
                r.src = SRC_W'(k);
            end
            default: begin
                r.en  = (k < w);
                r.src = SRC_W'(nib * w + k);
            end
        endcase
        return r;
    endfunction

    // Source pad pin for rx_data bit j
    function automatic lane_t rx_route(route_e m, int unsigned w, int unsigned j);
        lane_t r;
        int unsigned dev;
        int unsigned k;
        r = '0;
        if (m == ROUTE_OCT) begin
            r.en  = 1'b1;
            r.src = SRC_W'(j);
        end else begin
            if (m == ROUTE_DQ) begin
                r.en = (j < 2 * w);
                dev  = j / w;
                k    = j % w;
            end else begin
                r.en = (j < w);
                dev  = (m == ROUTE_HI) ? 1 : 0;
                k    = j;
            end
            if (w == 1) r.src = SRC_W'(dev * NIB_W + 1);
            else        r.src = SRC_W'(dev * NIB_W + k);
        end
        return r;
    endfunction

endpackage

// File: rtl/olr_cfg_reg.sv
module olr_cfg_reg
    import olr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic we,
    input  cfg_t wr_cfg,
    output cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst)              cfg_q <= CFG_RESET;
        else if (we && !busy) cfg_q <= wr_cfg;
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cfg_q)); // R6

    AST_CFG_LOADS: assert property (@(posedge clk) disable iff (rst)
        (we && !busy) |=> (cfg_q == $past(wr_cfg))); // R6

endmodule

// File: rtl/olr_tx_map.sv
module olr_tx_map
    import olr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  route_e          mode,
    input  logic [1:0]      lines,
    input  logic [IO_W-1:0] tx_data,
    input  logic            tx_oe,
    output logic [IO_W-1:0] pad_out,
    output logic [IO_W-1:0] pad_oe
);

    for (genvar p = 0; p < IO_W; p++) begin : g_pin
        lane_t r;
        assign r          = tx_route(mode, lane_count(lines), p);
        assign pad_oe[p]  = tx_oe & r.en;
        assign pad_out[p] = tx_oe & r.en & tx_data[r.src];
    end

    AST_LO_CONFINED: assert property (@(posedge clk) disable iff (rst)
        (mode == ROUTE_LO) |-> (pad_oe[IO_W-1:NIB_W] == '0)); // R1

    AST_HI_CONFINED: assert property (@(posedge clk) disable iff (rst)
        (mode == ROUTE_HI) |-> (pad_oe[NIB_W-1:0] == '0)); // R2

    AST_DQ_SYMMETRIC: assert property (@(posedge clk) disable iff (rst)
        (mode == ROUTE_DQ) |-> (pad_oe[NIB_W-1:0] == pad_oe[IO_W-1:NIB_W])); // R3

    AST_OCT_ALL_LANES: assert property (@(posedge clk) disable iff (rst)
        (mode == ROUTE_OCT && tx_oe) |-> (&pad_oe)); // R4

    AST_UNUSED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (pad_out & ~pad_oe) == '0); // R7

    AST_NO_DRIVE_RX: assert property (@(posedge clk) disable iff (rst)
        !tx_oe |-> (pad_oe == '0 && pad_out == '0)); // R8

endmodule

// File: rtl/olr_rx_map.sv
module olr_rx_map
    import olr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  route_e          mode,
    input  logic [1:0]      lines,
    input  logic [IO_W-1:0] pad_in,
    output logic [IO_W-1:0] rx_data
);

    for (genvar j = 0; j < IO_W; j++) begin : g_bit
        lane_t r;
        assign r          = rx_route(mode, lane_count(lines), j);
        assign rx_data[j] = r.en & pad_in[r.src];
    end

    AST_OCT_RX_STRAIGHT: assert property (@(posedge clk) disable iff (rst)
        (mode == ROUTE_OCT) |-> (rx_data == pad_in)); // R4

    AST_NARROW_RX_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
        (mode == ROUTE_LO || mode == ROUTE_HI) |-> (rx_data[IO_W-1:NIB_W] == '0)); // R7

endmodule

// File: rtl/octal_lane_router.sv
module octal_lane_router
    import olr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            busy,
    input  logic            cfg_we,
    input  logic            cfg_fsel,
    input  logic            cfg_dual,
    input  logic            cfg_octal,
    input  logic [1:0]      cfg_lines,
    input  logic [IO_W-1:0] tx_data,
    input  logic            tx_oe,
    input  logic [IO_W-1:0] pad_in,
    output logic [IO_W-1:0] pad_out,
    output logic [IO_W-1:0] pad_oe,
    output logic [IO_W-1:0] rx_data
);

    cfg_t   wr_cfg;
    cfg_t   cfg_q;
    route_e mode;

    assign wr_cfg = '{fsel: cfg_fsel, dual: cfg_dual, octal: cfg_octal, lines: cfg_lines};
    assign mode   = decode_route(cfg_q);

    olr_cfg_reg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .busy   (busy),
        .we     (cfg_we),
        .wr_cfg (wr_cfg),
        .cfg_q  (cfg_q)
    );

    olr_tx_map u_tx (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .lines   (cfg_q.lines),
        .tx_data (tx_data),
        .tx_oe   (tx_oe),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    olr_rx_map u_rx (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .lines   (cfg_q.lines),
        .pad_in  (pad_in),
        .rx_data (rx_data)
    );

    AST_RESET_NARROW_LOW: assert property (@(posedge clk)
        rst |=> (mode == ROUTE_LO && cfg_q.lines == 2'b00)); // R9

endmodule

// File: tb/sim_octal_lane_router.sv
module sim_octal_lane_router;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       busy = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_fsel = 1'b0;
    logic       cfg_dual = 1'b0;
    logic       cfg_octal = 1'b0;
    logic [1:0] cfg_lines = 2'b00;
    logic [7:0] tx_data = 8'hA5;
    logic       tx_oe = 1'b1;
    logic [7:0] pad_in = 8'h96;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;
    logic [7:0] rx_data;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    octal_lane_router u0 (
        .clk(clk), .rst(rst), .busy(busy), .cfg_we(cfg_we),
        .cfg_fsel(cfg_fsel), .cfg_dual(cfg_dual), .cfg_octal(cfg_octal),
        .cfg_lines(cfg_lines), .tx_data(tx_data), .tx_oe(tx_oe),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .rx_data(rx_data)
    );

    typedef struct packed {
        logic       fsel;
        logic       dual;
        logic       octal;
        logic [1:0] lines;
        logic [7:0] e_out;
        logic [7:0] e_oe;
        logic [7:0] e_rx;
        logic [3:0] req;
    } vec_t;

    // tx_data = A5, pad_in = 96, tx_oe = 1 throughout the table
    localparam int NVEC = 13;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 1'b0, 1'b0, 2'd0, 8'h01, 8'h01, 8'h01, 4'd1}, // R1 R5 single line, rx from pin 1
        '{1'b0, 1'b0, 1'b0, 2'd1, 8'h01, 8'h03, 8'h02, 4'd1}, // R1 two lines, R7 rest quiet
        '{1'b0, 1'b0, 1'b0, 2'd2, 8'h05, 8'h0F, 8'h06, 4'd1}, // R1 four lines
        '{1'b1, 1'b0, 1'b0, 2'd0, 8'h10, 8'h10, 8'h00, 4'd2}, // R2 R5 single line, rx from pin 5
        '{1'b1, 1'b0, 1'b0, 2'd2, 8'h50, 8'hF0, 8'h09, 4'd2}, // R2 four lines
        '{1'b1, 1'b0, 1'b0, 2'd1, 8'h10, 8'h30, 8'h01, 4'd2}, // R2 two lines
        '{1'b0, 1'b1, 1'b0, 2'd2, 8'hA5, 8'hFF, 8'h96, 4'd3}, // R3 four lines each
        '{1'b1, 1'b1, 1'b0, 2'd2, 8'hA5, 8'hFF, 8'h96, 4'd3}, // R3 fsel ignored
        '{1'b1, 1'b1, 1'b0, 2'd0, 8'h01, 8'h11, 8'h01, 4'd3}, // R3 single line each
        '{1'b0, 1'b1, 1'b0, 2'd1, 8'h11, 8'h33, 8'h06, 4'd3}, // R3 two lines each
        '{1'b1, 1'b0, 1'b1, 2'd0, 8'hA5, 8'hFF, 8'h96, 4'd4}, // R4 fsel and lines ignored
        '{1'b0, 1'b1, 1'b1, 2'd1, 8'hA5, 8'hFF, 8'h96, 4'd4}, // R4 octal over dual
        '{1'b0, 1'b0, 1'b0, 2'd3, 8'h05, 8'h0F, 8'h06, 4'd5}  // R5 code 11 means four
    };

    task automatic check8(string what, string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic write_cfg(logic f, logic d, logic o, logic [1:0] l);
        @(negedge clk);
        cfg_fsel = f; cfg_dual = d; cfg_octal = o; cfg_lines = l; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R9: reset selects lower nibble, single line
        check8("reset pad_out", "R9", pad_out, 8'h01);
        check8("reset pad_oe",  "R9", pad_oe,  8'h01);
        check8("reset rx_data", "R9", rx_data, 8'h01);

        for (int i = 0; i < NVEC; i++) begin
            write_cfg(VEC[i].fsel, VEC[i].dual, VEC[i].octal, VEC[i].lines);
            tx_data = 8'hA5; pad_in = 8'h96; tx_oe = 1'b1;
            #1;
            check8($sformatf("vec%0d pad_out", i), $sformatf("R%0d", VEC[i].req), pad_out, VEC[i].e_out);
            check8($sformatf("vec%0d pad_oe",  i), $sformatf("R%0d", VEC[i].req), pad_oe,  VEC[i].e_oe);
            check8($sformatf("vec%0d rx_data", i), $sformatf("R%0d", VEC[i].req), rx_data, VEC[i].e_rx);
        end

        // R6: write while busy is ignored, write when idle is taken
        write_cfg(1'b0, 1'b0, 1'b0, 2'd2);
        @(negedge clk);
        busy = 1'b1;
        cfg_fsel = 1'b1; cfg_we = 1'b1;
        @(negedge clk);
        #1;
        check8("busy write ignored", "R6", pad_oe, 8'h0F);
        busy = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        check8("idle write taken", "R6", pad_oe, 8'hF0);

        // R8: receive-only cycle in octal
        write_cfg(1'b0, 1'b0, 1'b1, 2'd0);
        tx_oe = 1'b0; tx_data = 8'hFF; pad_in = 8'h5A;
        #1;
        check8("rx-only pad_oe",  "R8", pad_oe,  8'h00);
        check8("rx-only pad_out", "R8", pad_out, 8'h00);
        check8("rx-only rx_data", "R8", rx_data, 8'h5A);

        // R7: different pad input in narrow upper mode leaves unused rx bits zero
        write_cfg(1'b1, 1'b0, 1'b0, 2'd2);
        tx_oe = 1'b1; tx_data = 8'h3C; pad_in = 8'hFF;
        #1;
        check8("narrow rx width", "R7", rx_data, 8'h0F);
        check8("narrow pad_out",  "R7", pad_out, 8'hC0);

        finish_run();
    end

endmodule